// File: doc/BRIEF.md
# Hub Event Interrupt and Status Reader

This block gathers the one-cycle event strobes raised by a USB hub core into sticky pending bits and drives a single active-low interrupt line whenever any bit is pending. A host microcontroller reads the pending bits over a two-wire, I2C-style serial bus. The block is a read-only slave on that bus. It recognises one fixed read address, acknowledges it, and then shifts out status bytes most significant bit first. The host can keep reading further status bytes by acknowledging each one.

Pending bits are cleared by the stop condition that closes a read in which at least one full data byte went out. Only the bits that were reported as set are cleared. The endpoint-1 data bit is the exception: it ignores status reads and is cleared only by a FIFO-read strobe. Open-drain drive is modelled as a drive-low enable. The bus line is released except while the slave sends a zero bit or its acknowledge.

Bit map: event input k sets pending bit k. Status byte n carries pending bits 8n+7 down to 8n, and positions beyond the event count read as zero. With the default nine events, the assignment is:
- byte 0 bit 0: port connect/disconnect change
- bit 1: downstream resume
- bit 2: endpoint-1 data received
- bit 3: endpoint-0 data received
- bit 4: turnaround time-out
- bit 5: bus suspend
- bit 6: reset from upstream
- bit 7: babble or data loss
- byte 1 bit 0: overcurrent trip

Top module: `hub_irq_unit`

## Requirements
- R1: After reset, irq_no is high, sda_oe_o is low and no event is pending.
- R2: A high evt_i[k] in a cycle sets pending bit k at that clock edge, so irq_no is low after that edge. The bit stays set until one of the clear rules below removes it.
- R3: The slave acknowledges only the address byte 8'hE9 (sent MSB first, read bit set). For any other address byte it leaves the line released through the acknowledge slot and all following bits until the next start.
- R4: After its address acknowledge, the slave sends status byte 0 MSB first. It holds the line steady while scl_i is high and changes it only after scl_i falls.
- R5: When the host acknowledges a data byte, the slave sends the next status byte (1, then wrapping back to 0).
- R6: When the host does not acknowledge a data byte, the slave releases the line until a stop or start.
- R7: The stop that ends a read in which at least one data byte was fully shifted out clears every non-endpoint-1 pending bit that was reported as 1. Pending bit 2 (endpoint-1 data) is never cleared by a read.
- R8: An event whose bit was reported as 0 during a read stays pending after that read's stop. It appears in the next read.
- R9: A high ep1_rd_i clears pending bit 2. If evt_i[2] is high in the same cycle, the bit stays set.
- R10: A read closed by a stop before any full data byte has been shifted out clears nothing.
- R11: irq_no is low exactly while at least one pending bit is set. It returns high only after a clear rule empties all pending bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock; the bus lines are oversampled on it |
| rst_ni | input | 1 | Asynchronous reset, active low |
| evt_i | input | NUM_EVT | Event strobes, one cycle per event |
| ep1_rd_i | input | 1 | Endpoint-1 FIFO read strobe |
| scl_i | input | 1 | Serial clock from the host |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | Drive-low enable for the serial data line |
| irq_no | output | 1 | Interrupt request, active low |

## Verification
Single events, several events in one register, and events spread over both status bytes are each read back. These cases separate the bit mapping, the byte order and the wrap after the last byte. Reads with a wrong address and reads stopped right after the address acknowledge show whether clearing depends on a completed byte. An event injected in the middle of a byte, and an endpoint-1 event pulsed together with its FIFO read, separate read-based clearing from FIFO-based clearing and show the set-over-clear priority. The interrupt output is compared to the reference model on every clock.

// File: rtl/hub_irq_pkg.sv
package hub_irq_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_ADDR,
    S_AACK,
    S_TX,
    S_MACK,
    S_WAIT
  } ser_state_e;

  function automatic int unsigned regs_for(int unsigned n);
    return (n + 7) / 8;
  endfunction
endpackage

// File: rtl/hub_irq_sync.sv
module hub_irq_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] in_i,
  output logic [W-1:0] lvl_o,
  output logic [W-1:0] rise_o,
  output logic [W-1:0] fall_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;
      else         ff_q <= {ff_q[STAGES-1:0], in_i[b]};
    end
    assign lvl_o[b]  = ff_q[STAGES-1];
    assign rise_o[b] = ff_q[STAGES-1] & ~ff_q[STAGES];
    assign fall_o[b] = ~ff_q[STAGES-1] & ff_q[STAGES];
  end
endmodule

// File: rtl/hub_irq_events.sv
module hub_irq_events #(
  parameter int unsigned NUM_EVT = 9,
  parameter int unsigned EP1_IDX = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ep1_rd_i,
  input  logic               clr_i,
  input  logic [NUM_EVT-1:0] clr_mask_i,
  output logic [NUM_EVT-1:0] pend_o,
  output logic               irq_no
);
  logic [NUM_EVT-1:0] pend_q;

  for (genvar k = 0; k < NUM_EVT; k++) begin : g_evt
    logic clr_k;
    if (k == EP1_IDX) begin : g_ep1
      assign clr_k = ep1_rd_i;
    end else begin : g_std
      assign clr_k = clr_i & clr_mask_i[k];
    end
    // set beats clear in the same cycle
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       pend_q[k] <= 1'b0;
      else if (evt_i[k]) pend_q[k] <= 1'b1;
      else if (clr_k)    pend_q[k] <= 1'b0;
    end
  end

  assign pend_o = pend_q;
  assign irq_no = ~|pend_q;
endmodule

// File: rtl/hub_irq_serial.sv
module hub_irq_serial
  import hub_irq_pkg::*;
#(
  parameter int unsigned NUM_EVT  = 9,
  parameter logic [7:0]  SLV_ADDR = 8'hE9
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               scl_i,
  input  logic               scl_rise_i,
  input  logic               scl_fall_i,
  input  logic               sda_i,
  input  logic               sda_rise_i,
  input  logic               sda_fall_i,
  input  logic [NUM_EVT-1:0] pend_i,
  output logic               sda_oe_o,
  output logic               clr_o,
  output logic [NUM_EVT-1:0] clr_mask_o
);
  localparam int unsigned NREG = regs_for(NUM_EVT);
  localparam int unsigned PADW = NREG * 8;
  localparam int unsigned IDXW = (NREG > 1) ? $clog2(NREG) : 1;

  ser_state_e      state_q;
  logic [3:0]      cnt_q;
  logic [7:0]      sh_q, snap_q;
  logic [IDXW-1:0] idx_q, nxt_idx;
  logic [PADW-1:0] mask_q, clr_mask_q, stat;
  logic            xfer_q, ack_q, oe_q, clr_q;
  logic            start_c, stop_c;
  logic [7:0]      cur_byte, nxt_byte;

  always_comb begin
    stat = '0;
    stat[NUM_EVT-1:0] = pend_i;
  end

  assign nxt_idx  = (idx_q == IDXW'(NREG - 1)) ? '0 : idx_q + 1'b1;
  assign cur_byte = stat[int'(idx_q)*8 +: 8];
  assign nxt_byte = stat[int'(nxt_idx)*8 +: 8];
  assign start_c  = scl_i & sda_fall_i;
  assign stop_c   = scl_i & sda_rise_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= S_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      snap_q     <= '0;
      idx_q      <= '0;
      mask_q     <= '0;
      clr_mask_q <= '0;
      xfer_q     <= 1'b0;
      ack_q      <= 1'b0;
      oe_q       <= 1'b0;
      clr_q      <= 1'b0;
    end else begin
      clr_q <= 1'b0;
      if (stop_c) begin
        state_q    <= S_IDLE;
        oe_q       <= 1'b0;
        clr_q      <= xfer_q;
        clr_mask_q <= mask_q;
        mask_q     <= '0;
        xfer_q     <= 1'b0;
      end else if (start_c) begin
        state_q <= S_ADDR;
        cnt_q   <= '0;
        idx_q   <= '0;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          S_ADDR: begin
            if (scl_rise_i) begin
              sh_q  <= {sh_q[6:0], sda_i};
              cnt_q <= cnt_q + 1'b1;
            end else if (scl_fall_i && cnt_q == 4'd8) begin
              if (sh_q == SLV_ADDR) begin
                state_q <= S_AACK;
                oe_q    <= 1'b1;
              end else begin
                state_q <= S_IDLE;
              end
            end
          end
          S_AACK: begin
            if (scl_fall_i) begin
              sh_q    <= cur_byte;
              snap_q  <= cur_byte;
              oe_q    <= ~cur_byte[7];
              cnt_q   <= '0;
              state_q <= S_TX;
            end
          end
          S_TX: begin
            if (scl_rise_i) begin
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == 4'd7) begin
                xfer_q <= 1'b1;
                mask_q[int'(idx_q)*8 +: 8] <= mask_q[int'(idx_q)*8 +: 8] | snap_q;
              end
            end else if (scl_fall_i) begin
              if (cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= S_MACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          S_MACK: begin
            if (scl_rise_i) begin
              ack_q <= ~sda_i;
            end else if (scl_fall_i) begin
              if (ack_q) begin
                idx_q   <= nxt_idx;
                sh_q    <= nxt_byte;
                snap_q  <= nxt_byte;
                oe_q    <= ~nxt_byte[7];
                cnt_q   <= '0;
                state_q <= S_TX;
              end else begin
                state_q <= S_WAIT;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o   = oe_q;
  assign clr_o      = clr_q;
  assign clr_mask_o = clr_mask_q[NUM_EVT-1:0];
endmodule

// File: rtl/hub_irq_unit.sv
module hub_irq_unit #(
  parameter int unsigned NUM_EVT  = 9,
  parameter int unsigned EP1_IDX  = 2,
  parameter logic [7:0]  SLV_ADDR = 8'hE9,
  parameter int unsigned SYNC_STG = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               ep1_rd_i,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_oe_o,
  output logic               irq_no
);
  logic [1:0]         bus_lvl, bus_rise, bus_fall;
  logic [NUM_EVT-1:0] pend_w, clr_mask_w;
  logic               clr_w;

  hub_irq_sync #(.W(2), .STAGES(SYNC_STG)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .in_i   ({scl_i, sda_i}),
    .lvl_o  (bus_lvl),
    .rise_o (bus_rise),
    .fall_o (bus_fall)
  );

  hub_irq_events #(.NUM_EVT(NUM_EVT), .EP1_IDX(EP1_IDX)) u_evt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .evt_i      (evt_i),
    .ep1_rd_i   (ep1_rd_i),
    .clr_i      (clr_w),
    .clr_mask_i (clr_mask_w),
    .pend_o     (pend_w),
    .irq_no     (irq_no)
  );

  hub_irq_serial #(.NUM_EVT(NUM_EVT), .SLV_ADDR(SLV_ADDR)) u_ser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .scl_i      (bus_lvl[1]),
    .scl_rise_i (bus_rise[1]),
    .scl_fall_i (bus_fall[1]),
    .sda_i      (bus_lvl[0]),
    .sda_rise_i (bus_rise[0]),
    .sda_fall_i (bus_fall[0]),
    .pend_i     (pend_w),
    .sda_oe_o   (sda_oe_o),
    .clr_o      (clr_w),
    .clr_mask_o (clr_mask_w)
  );
endmodule

// File: rtl/hub_irq_unit_chk.sv
module hub_irq_unit_chk #(
  parameter int unsigned NUM_EVT = 9,
  parameter int unsigned EP1_IDX = 2
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               ep1_rd_i,
  input logic               scl_i,
  input logic               sda_oe_o,
  input logic               irq_no,
  input logic [NUM_EVT-1:0] pend_w,
  input logic               clr_w
);
  localparam logic [NUM_EVT-1:0] EP1M = NUM_EVT'(1) << EP1_IDX;

  always @(posedge clk_i)
    if (!rst_ni) a_r1_reset_idle : assert (irq_no && !sda_oe_o);

  a_r2_evt_raises_irq : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> !irq_no);

  a_r11_irq_holds : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!irq_no && !clr_w && !ep1_rd_i) |=> !irq_no);

  a_r7_clear_at_stop : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|($past(pend_w) & ~pend_w & ~EP1M)) |-> $past(clr_w));

  a_r9_ep1_fifo_only : assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(pend_w[EP1_IDX]) && !pend_w[EP1_IDX]) |-> $past(ep1_rd_i));

  a_r4_sda_steady : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3))
      |-> ($stable(sda_oe_o) || !sda_oe_o));
endmodule

bind hub_irq_unit hub_irq_unit_chk #(.NUM_EVT(NUM_EVT), .EP1_IDX(EP1_IDX)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .evt_i    (evt_i),
  .ep1_rd_i (ep1_rd_i),
  .scl_i    (scl_i),
  .sda_oe_o (sda_oe_o),
  .irq_no   (irq_no),
  .pend_w   (pend_w),
  .clr_w    (clr_w)
);

// File: tb/sim_hub_irq_unit.sv
module sim_hub_irq_unit;
  localparam int CLK_PERIOD = 10;
  localparam int HALF       = 8;
  localparam int NE         = 9;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [NE-1:0] evt_i = '0;
  logic          ep1_rd_i = 1'b0;
  logic          scl_m = 1'b1, sda_m = 1'b1;
  logic          sda_i, sda_oe_o, irq_no;
  logic [NE-1:0] m_pend = '0;
  logic          cmp_en = 1'b0;
  logic          done = 1'b0;
  int            errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_i = sda_m & ~sda_oe_o;

  hub_irq_unit u0 (
    .clk_i(clk), .rst_ni(rst_ni), .evt_i(evt_i), .ep1_rd_i(ep1_rd_i),
    .scl_i(scl_m), .sda_i(sda_i), .sda_oe_o(sda_oe_o), .irq_no(irq_no)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-clock reference compare of the interrupt line (R2, R11)
  always @(posedge clk) begin
    #(CLK_PERIOD/4);
    if (rst_ni && cmp_en && !done)
      check(irq_no == ~|m_pend, "R2 R11 irq_no", irq_no, ~|m_pend);
  end

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic [NE-1:0] m, input bit rd);
    evt_i = m;
    ep1_rd_i = rd;
    m_pend = (m_pend & ~(rd ? NE'(4) : NE'(0))) | m;
    @(negedge clk);
    evt_i = '0;
    ep1_rd_i = 1'b0;
    wclk(2);
  endtask

  function automatic logic [7:0] model_byte(input int n);
    logic [15:0] p;
    p = 16'(m_pend);
    return p[(n%2)*8 +: 8];
  endfunction

  task automatic bit_out(input logic b);
    sda_m = b; wclk(HALF/2);
    scl_m = 1'b1; wclk(HALF);
    scl_m = 1'b0; wclk(HALF/2);
  endtask

  task automatic bit_in(output logic v);
    sda_m = 1'b1; wclk(HALF/2);
    scl_m = 1'b1; wclk(HALF/2);
    v = sda_i; wclk(HALF/2);
    scl_m = 1'b0; wclk(HALF/2);
  endtask

  task automatic bus_start();
    sda_m = 1'b0; wclk(HALF);
    scl_m = 1'b0; wclk(HALF/2);
  endtask

  task automatic bus_stop(input logic [NE-1:0] clr);
    sda_m = 1'b0; wclk(HALF/2);
    scl_m = 1'b1; wclk(HALF/2);
    cmp_en = 1'b0;
    sda_m = 1'b1; wclk(HALF);
    m_pend = m_pend & ~(clr & ~NE'(4));
    cmp_en = 1'b1;
    wclk(HALF);
  endtask

  // nbytes data bytes after the address; mid_evt fires inside byte 0
  task automatic do_read(input logic [7:0] addr, input int nbytes,
                         input logic [NE-1:0] mid_evt, input string tag);
    logic v, ack;
    logic [7:0] got, exp;
    logic [15:0] acc;
    acc = '0;
    bus_start();
    for (int i = 7; i >= 0; i--) bit_out(addr[i]);
    bit_in(ack);
    check(ack == (addr != 8'hE9), {tag, " R3 addr ack"}, ack, addr != 8'hE9);
    for (int n = 0; n < nbytes; n++) begin
      exp = model_byte(n);
      for (int b = 7; b >= 0; b--) begin
        if (n == 0 && b == 4 && mid_evt != '0) begin
          evt_i = mid_evt;
          m_pend = m_pend | mid_evt;
          @(negedge clk);
          evt_i = '0;
        end
        bit_in(v);
        got[b] = v;
      end
      if (addr == 8'hE9) begin
        check(got == exp, {tag, " R4 R5 data byte"}, got, exp);
        acc[(n%2)*8 +: 8] = acc[(n%2)*8 +: 8] | exp;
      end else begin
        check(got == 8'hFF, {tag, " R3 line released"}, got, 8'hFF);
      end
      bit_out(n == nbytes - 1);
    end
    if (nbytes > 0) check(sda_oe_o == 1'b0, {tag, " R6 release after nack"}, sda_oe_o, 0);
    bus_stop(acc[NE-1:0]);
  endtask

  initial begin
    wclk(3);
    check(irq_no == 1'b1 && sda_oe_o == 1'b0, "R1 reset state", {irq_no, sda_oe_o}, 2'b10);
    rst_ni = 1'b1;
    wclk(2);
    cmp_en = 1'b1;

    // R2 single event, R4 R7 read clears it
    pulse(NE'(9'h001), 1'b0);
    do_read(8'hE9, 1, '0, "single");
    check(irq_no == 1'b1, "R7 cleared after read", irq_no, 1);

    // R7 endpoint-1 bit survives read; R9 FIFO read clears
    pulse(NE'(9'h084), 1'b0);
    do_read(8'hE9, 1, '0, "ep1mix");
    check(irq_no == 1'b0, "R7 ep1 kept after read", irq_no, 0);
    pulse('0, 1'b1);
    check(irq_no == 1'b1, "R9 ep1 cleared by fifo read", irq_no, 1);

    // R9 set wins over FIFO read
    pulse(NE'(9'h004), 1'b1);
    check(irq_no == 1'b0, "R9 set beats clear", irq_no, 0);
    pulse('0, 1'b1);

    // R5 multi-byte with wrap
    pulse(NE'(9'h108), 1'b0);
    do_read(8'hE9, 3, '0, "multi");
    check(irq_no == 1'b1, "R5 R7 both bytes cleared", irq_no, 1);

    // R3 wrong address
    pulse(NE'(9'h020), 1'b0);
    do_read(8'hE8, 1, '0, "badaddr");
    check(irq_no == 1'b0, "R3 no clear on wrong address", irq_no, 0);

    // R10 address only, then real read
    pulse(NE'(9'h080), 1'b0);
    do_read(8'hE9, 0, '0, "addronly");
    check(irq_no == 1'b0, "R10 no clear without data", irq_no, 0);
    do_read(8'hE9, 1, '0, "after_r10");
    check(irq_no == 1'b1, "R10 later read clears", irq_no, 1);

    // R8 event during read held for next read
    pulse(NE'(9'h002), 1'b0);
    do_read(8'hE9, 1, NE'(9'h008), "midevt");
    check(irq_no == 1'b0, "R8 mid-read event held", irq_no, 0);
    do_read(8'hE9, 1, '0, "midevt2");
    check(irq_no == 1'b1, "R8 reported next read", irq_no, 1);

    wclk(5);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule